// File: doc/BRIEF.md
# Keyed Reset Line Controller

This block drives a bank of reset lines, one for each peripheral block, from a small memory-mapped register interface. Software writes a line-state word in which each low bit holds one line in reset while it is set. The write takes effect only when the top byte of the written word carries a fixed key value. This keeps a stray store from resetting half of the chip. A short reset pulse is produced by two keyed writes to the same bit: the first sets it and the second clears it.

An optional gate register, selected by a parameter, holds one software-control enable bit per line. When the gate is built in, a line can be held in reset only while its enable bit is set. Clearing an enable bit also releases that line. The intended software order is to enable the line, assert it, deassert it, and then disable it. Reads return the line states and the gate bits on a registered read port. All lines come out of power-on reset released, with every enable bit clear.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: After reset, every reset line is released (0), every gate bit is clear, and a read of either register returns zero.
- R2: A write to byte offset 0x18 whose bits 31:24 equal 0x88 loads the line states from bits NUM_LINES-1:0. When the gate is built in, the loaded value is masked by the gate bits. The lines show the new value on the clock edge that samples the write.
- R3: A write to offset 0x18 whose bits 31:24 differ from 0x88 leaves every line unchanged.
- R4: Offset 0xFC is the gate register, with bit i enabling software control of line i. A write to it needs no key and stores bits NUM_LINES-1:0, and a read returns them.
- R5: With the gate built in, a keyed write cannot set a line whose gate bit is clear, and no line is ever set while its gate bit is clear.
- R6: Writing 0 to a gate bit while its line is held releases that line on the same clock edge that stores the gate value.
- R7: A read returns its data on the cycle after rd_en is sampled. A read of offset 0x18 gives the line states in the low bits, with bits 31:NUM_LINES, the key byte included, reading as zero.
- R8: A keyed assert write followed later by a keyed deassert write to the same bit holds that line set on every cycle between the two writes and nowhere else.
- R9: Bits 23:NUM_LINES of a keyed write are ignored. Writes to any offset other than 0x18 and 0xFC change nothing, and reads of such offsets return zero.
- R10: With the gate not built in (HAS_GATE=0), offset 0xFC reads zero and ignores writes, and keyed writes drive the lines with no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data; bits 31:24 hold the key for the line-state register |
| rdata | output | 32 | Registered read data; holds the last read value |
| rst_lines_o | output | NUM_LINES | Reset lines, 1 = held in reset |

## Verification
The assertions assume the bus never presents a read and a write in the same cycle. They also assume that wdata and addr are meaningful only while a strobe is high. The bench drives each access as a single-strobe cycle set up at the falling edge, so those conditions always hold. The bench compares two instances built with eight lines, one with the gate and one without, and drives both with the same stimulus. It sweeps every gate value against a set of line patterns and every wrong key byte. It works out each expected line value as the pattern masked by the gate.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int DATA_W    = 32;
  localparam int KEY_LSB   = 24;
  localparam int KEY_W     = DATA_W - KEY_LSB;
  localparam logic [KEY_W-1:0] KEY_VALUE = 8'h88;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LINES = 2'd1,
    SRC_GATE  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
  import rstctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATE_OFS = 'h18,
  parameter logic [ADDR_W-1:0] GATE_OFS = 'hFC,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  key_in,
  output logic              state_wr,
  output logic              gate_wr,
  output rd_src_e           rd_src
);
  logic hit_state, hit_gate, key_ok;

  assign hit_state = (addr == STATE_OFS);
  assign hit_gate  = HAS_GATE && (addr == GATE_OFS);
  assign key_ok    = (key_in == KEY_VALUE);

  assign state_wr = wr_en && hit_state && key_ok;
  assign gate_wr  = wr_en && hit_gate;

  always_comb begin
    rd_src = SRC_NONE;
    if (hit_state)     rd_src = SRC_LINES;
    else if (hit_gate) rd_src = SRC_GATE;
  end

  // R9: a write never updates both registers in one cycle
  p_single_target_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({state_wr, gate_wr}));

  // R3: an accepted line-state write always carried the key
  p_key_required_r3: assert property (@(posedge clk) disable iff (rst)
    state_wr |-> (key_in == KEY_VALUE) && wr_en);
endmodule

// File: rtl/rstctl_lines.sv
module rstctl_lines #(
  parameter int NUM_LINES = 24,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 state_wr,
  input  logic                 gate_wr,
  input  logic [NUM_LINES-1:0] wd,
  output logic [NUM_LINES-1:0] line_q,
  output logic [NUM_LINES-1:0] gate_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (HAS_GATE) begin : g_gated
      always_ff @(posedge clk) begin
        if (rst) begin
          gate_q[i] <= 1'b0;
          line_q[i] <= 1'b0;
        end else if (gate_wr) begin
          gate_q[i] <= wd[i];
          if (!wd[i]) line_q[i] <= 1'b0;
        end else if (state_wr) begin
          line_q[i] <= wd[i] & gate_q[i];
        end
      end
    end else begin : g_plain
      assign gate_q[i] = 1'b0;
      always_ff @(posedge clk) begin
        if (rst)           line_q[i] <= 1'b0;
        else if (state_wr) line_q[i] <= wd[i];
      end
    end
  end

  if (HAS_GATE) begin : g_chk
    logic unused_gate_none;
    assign unused_gate_none = 1'b0;

    // R5: no line is held while its gate bit is clear
    p_gate_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (line_q & ~gate_q) == '0);

    // R6: lines whose gate bit was written 0 are released next
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
      gate_wr |=> (line_q & ~$past(wd)) == '0);
  end else begin : g_nochk
    logic unused_gate_wr;
    assign unused_gate_wr = gate_wr;
  end
endmodule

// File: rtl/rstctl_rdmux.sv
module rstctl_rdmux
  import rstctl_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  rd_src_e              rd_src,
  input  logic [NUM_LINES-1:0] line_q,
  input  logic [NUM_LINES-1:0] gate_q,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (rd_src)
      SRC_LINES: rd_next[NUM_LINES-1:0] = line_q;
      SRC_GATE:  rd_next[NUM_LINES-1:0] = gate_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R7: key byte of any read comes back zero
  p_key_byte_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata[DATA_W-1:KEY_LSB] == '0);

  // R7: read data is held until the next read
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl
  import rstctl_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter bit HAS_GATE = 1'b1,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATE_OFS = 'h18,
  parameter logic [ADDR_W-1:0] GATE_OFS = 'hFC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] rst_lines_o
);
  localparam int PAD_W = KEY_LSB - NUM_LINES;

  logic                 state_wr, gate_wr;
  rd_src_e              rd_src;
  logic [NUM_LINES-1:0] line_q, gate_q, mask_eff;

  rstctl_decode #(
    .ADDR_W(ADDR_W), .STATE_OFS(STATE_OFS), .GATE_OFS(GATE_OFS), .HAS_GATE(HAS_GATE)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .key_in(wdata[DATA_W-1:KEY_LSB]),
    .state_wr(state_wr), .gate_wr(gate_wr), .rd_src(rd_src)
  );

  rstctl_lines #(.NUM_LINES(NUM_LINES), .HAS_GATE(HAS_GATE)) u_lines (
    .clk(clk), .rst(rst), .state_wr(state_wr), .gate_wr(gate_wr),
    .wd(wdata[NUM_LINES-1:0]), .line_q(line_q), .gate_q(gate_q)
  );

  rstctl_rdmux #(.NUM_LINES(NUM_LINES)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_src(rd_src),
    .line_q(line_q), .gate_q(gate_q), .rdata(rdata)
  );

  assign rst_lines_o = line_q;
  assign mask_eff    = HAS_GATE ? gate_q : '1;

  if (PAD_W > 0) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^wdata[KEY_LSB-1:NUM_LINES];
  end

  // R2: keyed write loads the masked pattern onto the lines
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STATE_OFS && wdata[DATA_W-1:KEY_LSB] == KEY_VALUE)
    |=> rst_lines_o == ($past(wdata[NUM_LINES-1:0]) & $past(mask_eff)));

  // R3: a wrong key leaves the lines alone
  p_badkey_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STATE_OFS && wdata[DATA_W-1:KEY_LSB] != KEY_VALUE)
    |=> $stable(rst_lines_o));

  // R9: accesses elsewhere leave the lines alone
  p_other_ofs_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != STATE_OFS && addr != GATE_OFS) |=> $stable(rst_lines_o));

  // R7: bus never issues read and write together (input assumption)
  p_no_rw_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: tb/tb_keyed_reset_ctrl.sv
module tb_keyed_reset_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_g, rdata_n;
  logic [N-1:0] lines_g, lines_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  keyed_reset_ctrl #(.NUM_LINES(N), .HAS_GATE(1'b1)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_g), .rst_lines_o(lines_g));

  keyed_reset_ctrl #(.NUM_LINES(N), .HAS_GATE(1'b0)) dut_ng (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_n), .rst_lines_o(lines_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] kw(input logic [7:0] pat);
    return {8'h88, 16'h0000, pat};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 lines", {24'h0, lines_g}, 32'h0);
    chk("R1 lines nogate", {24'h0, lines_n}, 32'h0);
    chk("R1 rdata", rdata_g, 32'h0);
    rd(8'hFC); chk("R1 gate read", rdata_g, 32'h0);
    rd(8'h18); chk("R1 state read", rdata_g, 32'h0);

    // R2 R4 R5 R10: sweep every gate value against line patterns
    for (int en = 0; en < 256; en++) begin
      wr(8'hFC, {24'h0, 8'(en)});
      rd(8'hFC);
      chk("R4 gate readback", rdata_g, {24'h0, 8'(en)});
      chk("R10 gate absent reads zero", rdata_n, 32'h0);
      for (int p = 0; p < 16; p++) begin
        logic [7:0] pat;
        pat = 8'((p * 29) ^ (en >> 1) ^ (p << 4));
        wr(8'h18, kw(pat));
        chk("R2/R5 gated lines", {24'h0, lines_g}, {24'h0, pat & 8'(en)});
        chk("R10 ungated lines", {24'h0, lines_n}, {24'h0, pat});
      end
    end

    // R3: every wrong key byte
    wr(8'hFC, 32'hFF);
    wr(8'h18, kw(8'h5A));
    chk("R2 preload", {24'h0, lines_g}, 32'h5A);
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h88) begin
        wr(8'h18, {8'(k), 16'h0000, 8'hA5});
        chk("R3 bad key gated", {24'h0, lines_g}, 32'h5A);
        chk("R3 bad key ungated", {24'h0, lines_n}, 32'h5A);
      end
    end

    // R6: clearing gate bits releases held lines
    wr(8'h18, kw(8'hFF));
    chk("R6 pre", {24'h0, lines_g}, 32'hFF);
    wr(8'hFC, 32'h0F);
    chk("R6 release", {24'h0, lines_g}, 32'h0F);
    chk("R10 gate write ignored", {24'h0, lines_n}, 32'hFF);
    rd(8'hFC);
    chk("R4 gate after clear", rdata_g, 32'h0F);

    // R7 R9: upper data bits ignored, key byte reads zero
    wr(8'h18, 32'h88ABCD3C);
    chk("R9 upper bits ignored", {24'h0, lines_g}, 32'h0C);
    rd(8'h18);
    chk("R7 state read gated", rdata_g, 32'h0000000C);
    chk("R7 state read ungated", rdata_n, 32'h0000003C);

    // R9: other offsets
    wr(8'h10, 32'h880000FF);
    chk("R9 other offset write", {24'h0, lines_g}, 32'h0C);
    chk("R9 other offset write ng", {24'h0, lines_n}, 32'h3C);
    rd(8'h10);
    chk("R9 other offset read", rdata_g, 32'h0);

    // R8: pulse reset on one bit
    wr(8'hFC, 32'hFF);
    wr(8'h18, kw(8'h00));
    wr(8'h18, kw(8'h04));
    chk("R8 pulse high", {24'h0, lines_g}, 32'h04);
    @(negedge clk); chk("R8 pulse held", {24'h0, lines_g}, 32'h04);
    @(negedge clk); chk("R8 pulse held", {24'h0, lines_g}, 32'h04);
    wr(8'h18, kw(8'h00));
    chk("R8 pulse low", {24'h0, lines_g}, 32'h00);
    @(negedge clk); chk("R8 stays low", {24'h0, lines_g}, 32'h00);

    // R1: reset again mid-run
    wr(8'h18, kw(8'hC3));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rerun lines", {24'h0, lines_g}, 32'h0);
    chk("R1 rerun lines ng", {24'h0, lines_n}, 32'h0);
    rd(8'hFC);
    chk("R1 rerun gate", rdata_g, 32'h0);
    wr(8'h18, kw(8'h11));
    chk("R5 gate cleared by reset", {24'h0, lines_g}, 32'h0);

    finish_run();
  end
endmodule